// File: doc/BRIEF.md
# Codec Calibration Sequencer

This block orders the self-calibration of an audio codec. A two-bit mode field chooses one of four sequences. Each sequence mutes the outputs it could disturb, then fires one-clock strobes to the calibration engines in a fixed order, and finally lifts the mutes. The engines are the mixer offset engine, the ADC engine and the DAC engine, plus a clear strobe for the DAC interpolation filter. Each step lasts a parameterised number of sample periods, counted on a one-clock sample-rate tick. The block does not model the analog work. It only keeps each step open for its allotted number of sample periods.

Software starts a sequence with a one-clock start request. A power-up or power-down-exit event always forces the full sequence, whatever the mode field holds and whether or not a sequence is running. A busy flag covers the whole sequence. A one-clock done pulse marks its end.

Top module: `cal_seq`

## Requirements
- R1: After reset, all outputs (`dac_mute`, `mix_mute`, the four strobes, `busy`, `done`) are 0.
- R2: Mode field 2'b00 runs no calibration. `done` is 1 in the cycle after the start request, and `busy`, the mutes and all strobes stay 0.
- R3: Mode 2'b01 sets `dac_mute` only (not `mix_mute`). It pulses `adc_cal_go` and then `dac_cal_go`. The two steps last 160 and 161 sample ticks, 321 in total.
- R4: Mode 2'b10 sets `dac_mute` only. It pulses `dac_flt_clr` once for a step of 120 ticks and never pulses `adc_cal_go`.
- R5: Mode 2'b11 sets both mutes. It pulses `mix_cal_go`, `adc_cal_go` and `dac_cal_go` in that order, for 130, 160 and 160 ticks (450 in total).
- R6: Each strobe lasts one clock, and at most one strobe is high at a time. The first step's strobe comes in the cycle after the request. Each later strobe comes in the cycle after the tick that ends the previous step.
- R7: The mutes fall on the tick that ends the last step. `busy` stays high until the next tick, where it falls and `done` pulses for one clock.
- R8: `pwr_event` starts the full (2'b11) sequence from its first step whatever the mode field holds. This applies even while a sequence is running.
- R9: The mode field is captured at start. Changing it during a sequence does not alter that sequence's strobes or length.
- R10: A `start_req` while `busy` is 1 is ignored. The running sequence keeps its strobe order and length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Calibration mode field |
| start_req | input | 1 | One-clock start request |
| pwr_event | input | 1 | Power-up / power-down-exit event, forces full calibration |
| fs_tick | input | 1 | One-clock pulse per sample period |
| dac_mute | output | 1 | Mute for DAC outputs |
| mix_mute | output | 1 | Mute for mixer outputs |
| mix_cal_go | output | 1 | Start strobe to mixer calibration engine |
| adc_cal_go | output | 1 | Start strobe to ADC calibration engine |
| dac_cal_go | output | 1 | Start strobe to DAC calibration engine |
| dac_flt_clr | output | 1 | Clear strobe to DAC interpolation filter |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock pulse at the end of a sequence |

## Verification
The hardest states to reach are disturbances in the middle of a long sequence: a new start request, a mode-field change, and a power event arriving while a step counter is part way through. The bench drives ticks every third clock and injects a mode change and a stray start request at fixed cycles within every sequence. It also fires a power event in the middle of a filter-clear run. It then rebuilds the strobe order and the tick offset of every strobe, and compares them against prefix sums of the step lengths.

// File: rtl/cal_seq_pkg.sv
// Package cal_seq_pkg
// Shared types for the calibration sequencer: mode codes, step kinds and
// controller states. Assumes two-bit mode and step encodings.
package cal_seq_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_CONV = 2'b01,
        MODE_FILT = 2'b10,
        MODE_FULL = 2'b11
    } cal_mode_e;

    typedef enum logic [1:0] {
        STEP_MIX = 2'd0,
        STEP_ADC = 2'd1,
        STEP_DAC = 2'd2,
        STEP_CLR = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } seq_st_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cal_seq_plan.sv
// Module cal_seq_plan
// Pure lookup: for a captured mode and a step index, gives the kind of step,
// its length in sample ticks and whether it is the final step.
// Assumes the index never exceeds the number of steps of the mode.
module cal_seq_plan
    import cal_seq_pkg::*;
#(
    parameter int MIX_FULL = 130,
    parameter int ADC_FULL = 160,
    parameter int DAC_FULL = 160,
    parameter int ADC_CONV = 160,
    parameter int DAC_CONV = 161,
    parameter int CLR_FILT = 120,
    parameter int DUR_W    = 9
) (
    input  cal_mode_e        mode,
    input  logic [1:0]       idx,
    output step_e            kind,
    output logic [DUR_W-1:0] dur,
    output logic             last
);

    // Decode step kind, length and end-of-sequence for the current index.
    always_comb begin
        kind = STEP_MIX;
        dur  = DUR_W'(1);
        last = 1'b1;
        unique case (mode)
            MODE_CONV: begin
                kind = (idx == 2'd0) ? STEP_ADC : STEP_DAC;
                dur  = (idx == 2'd0) ? DUR_W'(ADC_CONV) : DUR_W'(DAC_CONV);
                last = (idx == 2'd1);
            end
            MODE_FILT: begin
                kind = STEP_CLR;
                dur  = DUR_W'(CLR_FILT);
                last = 1'b1;
            end
            MODE_FULL: begin
                case (idx)
                    2'd0:    begin kind = STEP_MIX; dur = DUR_W'(MIX_FULL); end
                    2'd1:    begin kind = STEP_ADC; dur = DUR_W'(ADC_FULL); end
                    default: begin kind = STEP_DAC; dur = DUR_W'(DAC_FULL); end
                endcase
                last = (idx == 2'd2);
            end
            default: begin
                kind = STEP_MIX;
                dur  = DUR_W'(1);
                last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cal_seq_timer.sv
// Module cal_seq_timer
// Counts sample ticks within one step and flags the tick that completes it.
// Assumes limit >= 1 and stays constant while a step runs; clr wins over tick.
module cal_seq_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);

    logic [W-1:0] cnt;

    assign expire = tick && (cnt == limit - W'(1));

    // Advance on each tick, wrap to zero at the end of a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + W'(1);
        end
    end

    // R6: a step only progresses on sample ticks
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt));

endmodule

// File: rtl/cal_seq.sv
// Module cal_seq
// Calibration sequencer top. Captures the mode on a start request (or forces
// full mode on a power event), mutes the affected outputs, fires one strobe
// per step, waits each step's tick count, unmutes and signals done one tick
// later. Assumes fs_tick is a one-clock pulse per sample period.
module cal_seq
    import cal_seq_pkg::*;
#(
    parameter int MIX_FULL = 130,
    parameter int ADC_FULL = 160,
    parameter int DAC_FULL = 160,
    parameter int ADC_CONV = 160,
    parameter int DAC_CONV = 161,
    parameter int CLR_FILT = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       start_req,
    input  logic       pwr_event,
    input  logic       fs_tick,
    output logic       dac_mute,
    output logic       mix_mute,
    output logic       mix_cal_go,
    output logic       adc_cal_go,
    output logic       dac_cal_go,
    output logic       dac_flt_clr,
    output logic       busy,
    output logic       done
);

    localparam int MAX_DUR = imax(imax(imax(MIX_FULL, ADC_FULL), imax(DAC_FULL, ADC_CONV)),
                                  imax(DAC_CONV, CLR_FILT));
    localparam int DUR_W   = $clog2(MAX_DUR + 1);
    localparam int N_KIND  = 4;

    seq_st_e          st_q;
    cal_mode_e        mode_q;
    cal_mode_e        launch_mode;
    logic [1:0]       idx_q;
    logic             fire_q;
    logic             done_q;
    logic             dmute_q;
    logic             mmute_q;
    logic             launch;
    logic             expire;
    logic             last;
    step_e            cur_kind;
    logic [DUR_W-1:0] cur_dur;
    logic [N_KIND-1:0] go_vec;

    // Request qualification: user start only when idle, power event always.
    assign launch      = pwr_event || (start_req && st_q == SQ_IDLE);
    assign launch_mode = pwr_event ? MODE_FULL : cal_mode_e'(mode_sel);

    cal_seq_plan #(
        .MIX_FULL(MIX_FULL), .ADC_FULL(ADC_FULL), .DAC_FULL(DAC_FULL),
        .ADC_CONV(ADC_CONV), .DAC_CONV(DAC_CONV), .CLR_FILT(CLR_FILT),
        .DUR_W(DUR_W)
    ) u_plan (
        .mode (mode_q),
        .idx  (idx_q),
        .kind (cur_kind),
        .dur  (cur_dur),
        .last (last)
    );

    cal_seq_timer #(.W(DUR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (launch),
        .tick   (fs_tick && st_q == SQ_RUN),
        .limit  (cur_dur),
        .expire (expire)
    );

    // Sequence control: launch, step advance, unmute and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            mode_q  <= MODE_NONE;
            idx_q   <= 2'd0;
            fire_q  <= 1'b0;
            done_q  <= 1'b0;
            dmute_q <= 1'b0;
            mmute_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            done_q <= 1'b0;
            if (launch) begin
                if (launch_mode == MODE_NONE) begin
                    done_q <= 1'b1;
                end else begin
                    st_q    <= SQ_RUN;
                    mode_q  <= launch_mode;
                    idx_q   <= 2'd0;
                    fire_q  <= 1'b1;
                    dmute_q <= 1'b1;
                    mmute_q <= (launch_mode == MODE_FULL);
                end
            end else begin
                case (st_q)
                    SQ_RUN: begin
                        if (expire) begin
                            if (last) begin
                                st_q    <= SQ_FIN;
                                dmute_q <= 1'b0;
                                mmute_q <= 1'b0;
                            end else begin
                                idx_q  <= idx_q + 2'd1;
                                fire_q <= 1'b1;
                            end
                        end
                    end
                    SQ_FIN: begin
                        if (fs_tick) begin
                            st_q   <= SQ_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // One strobe line per step kind, high for the clock after the step opens.
    for (genvar k = 0; k < N_KIND; k++) begin : g_strobe
        assign go_vec[k] = fire_q && (cur_kind == step_e'(k));
    end

    assign mix_cal_go  = go_vec[STEP_MIX];
    assign adc_cal_go  = go_vec[STEP_ADC];
    assign dac_cal_go  = go_vec[STEP_DAC];
    assign dac_flt_clr = go_vec[STEP_CLR];
    assign dac_mute    = dmute_q;
    assign mix_mute    = mmute_q;
    assign busy        = (st_q != SQ_IDLE);
    assign done        = done_q;

    // R6: never two engines started together
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(go_vec) <= 1);
    // R6: strobes only inside a sequence
    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|go_vec) |-> busy);
    // R7: outputs muted only while a sequence runs
    p_mute_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_mute || mix_mute) |-> busy);
    // R5: the mixer is muted only together with the DACs
    p_mix_with_dac_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mix_mute |-> dac_mute);
    // R7: completion is never reported while busy
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: busy can only end on a sample tick
    p_busy_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fs_tick) |=> busy);
    // R8: a power event always leads to full, fully muted calibration
    p_pwr_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_event |=> (busy && mix_mute && dac_mute));

endmodule

// File: tb/cal_seq_test.sv
module cal_seq_test;

    localparam int MIX_F = 130;
    localparam int ADC_F = 160;
    localparam int DAC_F = 160;
    localparam int ADC_C = 160;
    localparam int DAC_C = 161;
    localparam int CLR_2 = 120;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       start_req = 1'b0;
    logic       pwr_event = 1'b0;
    logic       fs_tick = 1'b0;
    logic       dac_mute, mix_mute, mix_cal_go, adc_cal_go, dac_cal_go, dac_flt_clr, busy, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cal_seq uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .start_req(start_req),
        .pwr_event(pwr_event), .fs_tick(fs_tick), .dac_mute(dac_mute), .mix_mute(mix_mute),
        .mix_cal_go(mix_cal_go), .adc_cal_go(adc_cal_go), .dac_cal_go(dac_cal_go),
        .dac_flt_clr(dac_flt_clr), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a start request or power event for one edge, then sample after it.
    task automatic issue(input logic [1:0] m, input bit pwr);
        @(negedge clk);
        mode_sel = m;
        fs_tick  = 1'b0;
        if (pwr) pwr_event = 1'b1; else start_req = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        pwr_event = 1'b0;
        start_req = 1'b0;
        #1;
    endtask

    // Follow one sequence of effective mode em from the sample right after launch.
    task automatic observe(input int em, input string tag);
        int ticks = 0;
        int ns = 0;
        int kinds[4];
        int pos[4];
        int ek[4];
        int ep[4];
        int en = 0;
        int total = 0;
        bit seen_done = 0;
        bit bprev;
        int c = 0;
        case (em)
            1: begin en = 2; ek[0] = 1; ek[1] = 2; ep[0] = 0; ep[1] = ADC_C; total = 321; end
            2: begin en = 1; ek[0] = 3; ep[0] = 0; total = 120; end
            3: begin en = 3; ek[0] = 0; ek[1] = 1; ek[2] = 2;
                     ep[0] = 0; ep[1] = MIX_F; ep[2] = MIX_F + ADC_F; total = 450; end
            default: begin en = 0; total = 0; end
        endcase
        // mutes right after launch (R2 none, R3/R4 DAC only, R5 both)
        check(dac_mute === (em != 0), {tag, " R3 R4 R5 dac_mute at launch"}, int'(dac_mute), int'(em != 0));
        check(mix_mute === (em == 3), {tag, " R5 mix_mute at launch"}, int'(mix_mute), int'(em == 3));
        while (c < 5000) begin
            if (mix_cal_go)  begin if (ns < 4) begin kinds[ns] = 0; pos[ns] = ticks; end ns++; end
            if (adc_cal_go)  begin if (ns < 4) begin kinds[ns] = 1; pos[ns] = ticks; end ns++; end
            if (dac_cal_go)  begin if (ns < 4) begin kinds[ns] = 2; pos[ns] = ticks; end ns++; end
            if (dac_flt_clr) begin if (ns < 4) begin kinds[ns] = 3; pos[ns] = ticks; end ns++; end
            if ((mix_cal_go || adc_cal_go || dac_cal_go || dac_flt_clr) && em != 0)
                check(dac_mute === 1'b1 && mix_mute === (em == 3), {tag, " R7 mutes held during steps"},
                      int'({mix_mute, dac_mute}), (em == 3) ? 3 : 1);
            if (done) begin seen_done = 1; break; end
            bprev = busy;
            @(negedge clk);
            fs_tick = (c % 3 == 2);
            if (c == 5) mode_sel = 2'b00;       // R9 mode change mid-sequence
            start_req = (c == 10);              // R10 stray start while busy
            c++;
            @(posedge clk); #1;
            if (fs_tick && bprev) ticks++;
        end
        @(negedge clk); fs_tick = 1'b0; start_req = 1'b0;
        check(seen_done, {tag, " R7 done seen"}, int'(seen_done), 1);
        check(ticks == total + ((em != 0) ? 1 : 0), {tag, " R3 R4 R5 R7 ticks to done"},
              ticks, total + ((em != 0) ? 1 : 0));
        check(ns == en, {tag, " R6 R9 R10 strobe count"}, ns, en);
        for (int i = 0; i < en && i < ns; i++) begin
            check(kinds[i] == ek[i], {tag, " R6 strobe order"}, kinds[i], ek[i]);
            check(pos[i] == ep[i], {tag, " R6 strobe tick offset"}, pos[i], ep[i]);
        end
        if (em == 0)
            check(c == 0, {tag, " R2 done in cycle after request"}, c, 0);
        check(!dac_mute && !mix_mute, {tag, " R7 unmuted at done"}, int'({mix_mute, dac_mute}), 0);
        @(posedge clk); #1;
        check(!done && !busy, {tag, " R7 done one clock, idle after"}, int'({busy, done}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check({dac_mute, mix_mute, mix_cal_go, adc_cal_go, dac_cal_go, dac_flt_clr, busy, done} == 8'd0,
              "R1 reset outputs", int'({dac_mute, mix_mute, mix_cal_go, adc_cal_go, dac_cal_go, dac_flt_clr, busy, done}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(!busy && !done, "R1 idle after reset release", int'({busy, done}), 0);

        // sweep every mode through a start request
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            mode_sel = 2'(m);
            fs_tick = 1'b0;
            start_req = 1'b1;
            @(posedge clk); #1;
            observe(m, $sformatf("start mode %0d", m));
        end

        // R8: power event forces full calibration whatever the field says
        for (int m = 0; m < 3; m++) begin
            @(negedge clk);
            mode_sel = 2'(m);
            fs_tick = 1'b0;
            pwr_event = 1'b1;
            @(posedge clk); #1;
            @(negedge clk); pwr_event = 1'b0; #1;
            // pwr_event released; the sample taken after the edge stands
            observe(3, $sformatf("R8 power event field %0d", m));
        end

        // R8: power event during a filter-clear run restarts from the full first step
        issue(2'b10, 1'b0);
        check(busy === 1'b1, "R4 filter clear running before restart", int'(busy), 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); fs_tick = (i % 3 == 0);
        end
        @(negedge clk);
        fs_tick = 1'b0;
        pwr_event = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); pwr_event = 1'b0; #1;
        observe(3, "R8 restart while busy");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule